// File: doc/BRIEF.md
# Floppy Board Control and Hang-Up Timer Port

This block sits between a host bus and a floppy disk controller board. The host writes one 8-bit control byte that sets four persistent board controls: a reset line to the controller, a gate on the DMA acknowledge path, an active-low motor line and an interrupt mask. The same byte carries a trigger bit that starts a retriggerable one-shot hang-up timer. Software uses the timer to time motor spin-down or to catch a transfer that has stalled. When the timer runs out with the mask set, an interrupt flag latches.

A separate status byte is sampled every clock. It carries the three board jumper positions, the inverted drive-ready line and four bits tied high. The timer period is a parameter counted in clock cycles, so the same RTL can run with a realistic period of about 100 ms or with a few cycles in simulation.

Top module: `fdc_ctl_top`

## Requirements
- R1: While `rst` is high, `fdc_reset` is 1. After reset, `motor_on` is 0, the DMA gate is closed and `timer_irq` is 0.
- R2: `fdc_reset` is the OR of `rst` and control bit 7 from the last write. A write takes effect on the clock edge that samples it.
- R3: `dma_ack_out` follows `dma_ack_in` only while the last written bit 4 is 1. Otherwise `dma_ack_out` is 0.
- R4: `motor_on` is the inverse of the last written bit 3. Writing 0 drives it high and writing 1 drives it low.
- R5: A write with bit 0 = 1 starts the timer. If bit 2 (the mask) is 1 at expiry, `timer_irq` rises exactly PERIOD clock edges after the write edge.
- R6: A trigger write before expiry restarts the full PERIOD from that write's edge, and no interrupt occurs in between.
- R7: If the mask bit is 0 when the timer expires, `timer_irq` stays 0.
- R8: Once high, `timer_irq` stays high until the next write with bit 0 = 1, or until reset. That write clears it on its edge.
- R9: The status byte `stat_rdata` holds `jumper_open[2:0]` in bits 7..5, with 1 meaning open and 0 meaning shorted, and reads 1 in bits 3..0. It is registered, with one edge of latency.
- R10: Status bit 4 is the inverse of `drive_ready`: a high input reads 0 and a low input reads 1.
- R11: Bits 6, 5 and 1 have no effect. A write with bit 0 = 0 neither starts the timer nor alters the interrupt flag. Without a write, the control outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Board clock |
| rst | input | 1 | Synchronous active-high power-on/switch reset |
| host_wr | input | 1 | Control byte write strobe |
| host_wdata | input | 8 | Control byte |
| drive_ready | input | 1 | Drive ready line from the drive |
| jumper_open | input | 3 | Jumper positions, 1 = open |
| dma_ack_in | input | 1 | DMA acknowledge from the DMA channel |
| stat_rdata | output | 8 | Registered status byte |
| fdc_reset | output | 1 | Reset to the floppy controller |
| dma_ack_out | output | 1 | Gated DMA acknowledge to the controller |
| motor_on | output | 1 | Motor-on line, active low relative to the control bit |
| timer_irq | output | 1 | Latched hang-up timer interrupt |

## Verification
The bench writes all 256 control byte values and checks every control output. This exposes any bit-position swap and any influence from the unused bits, and it tests the DMA gate with the acknowledge both high and low. The status port is driven through all 16 combinations of jumper and ready inputs, which separates bit placement from polarity. The timer is retriggered at every offset inside its period and must fire exactly one period after the last trigger, which catches off-by-one counts and a retrigger that fails to restart. Further sequences check expiry with the mask clear, holding of the flag across non-trigger writes, and clearing of the flag by a trigger write and by reset.

// File: rtl/fdc_ctl_pkg.sv
package fdc_ctl_pkg;

  localparam int CTRL_W    = 8;
  localparam int BIT_RST   = 7;
  localparam int BIT_DMAE  = 4;
  localparam int BIT_MOTOR = 3;
  localparam int BIT_MASK  = 2;
  localparam int BIT_TRIG  = 0;

  localparam int JMP_W     = 3;
  localparam int STAT_W    = 8;

  typedef struct packed {
    logic ctl_rst;
    logic dma_en;
    logic motor_bit;
    logic irq_mask;
  } ctrl_t;

  localparam ctrl_t CTRL_RESET = '{ctl_rst: 1'b0, dma_en: 1'b0,
                                   motor_bit: 1'b1, irq_mask: 1'b0};

  function automatic ctrl_t decode_ctrl(input logic [CTRL_W-1:0] b);
    ctrl_t c;
    c.ctl_rst   = b[BIT_RST];
    c.dma_en    = b[BIT_DMAE];
    c.motor_bit = b[BIT_MOTOR];
    c.irq_mask  = b[BIT_MASK];
    return c;
  endfunction

endpackage

// File: rtl/fdc_ctl_regs.sv
module fdc_ctl_regs
  import fdc_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wdata,
  output ctrl_t             ctrl_q,
  output logic              trig
);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= CTRL_RESET;
    end else if (wr_en) begin
      ctrl_q <= decode_ctrl(wdata);
    end
  end

  assign trig = wr_en & wdata[BIT_TRIG];

endmodule

// File: rtl/fdc_hang_timer.sv
module fdc_hang_timer #(
  parameter int PERIOD = 40
) (
  input  logic clk,
  input  logic rst,
  input  logic trig,
  input  logic mask,
  output logic irq
);

  localparam int CNT_W = $clog2(PERIOD + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(PERIOD);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             irq_q;
  logic             expire;

  assign expire = (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else if (trig) begin
      cnt_q <= LOAD;
      irq_q <= 1'b0;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - LAST;
      if (expire && mask) begin
        irq_q <= 1'b1;
      end
    end
  end

  assign irq = irq_q;

endmodule

// File: rtl/fdc_stat_port.sv
module fdc_stat_port
  import fdc_ctl_pkg::*;
(
  input  logic             clk,
  input  logic             ready_in,
  input  logic [JMP_W-1:0] jumpers,
  output logic [STAT_W-1:0] stat_q
);

  localparam int FILL_W = STAT_W - JMP_W - 1;

  always_ff @(posedge clk) begin
    stat_q <= {jumpers, ~ready_in, {FILL_W{1'b1}}};
  end

endmodule

// File: rtl/fdc_ctl_top.sv
module fdc_ctl_top
  import fdc_ctl_pkg::*;
#(
  parameter int PERIOD = 40
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       host_wr,
  input  logic [7:0] host_wdata,
  input  logic       drive_ready,
  input  logic [2:0] jumper_open,
  input  logic       dma_ack_in,
  output logic [7:0] stat_rdata,
  output logic       fdc_reset,
  output logic       dma_ack_out,
  output logic       motor_on,
  output logic       timer_irq
);

  ctrl_t ctrl;
  logic  trig;

  fdc_ctl_regs u_regs (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (host_wr),
    .wdata  (host_wdata),
    .ctrl_q (ctrl),
    .trig   (trig)
  );

  fdc_hang_timer #(.PERIOD(PERIOD)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .trig (trig),
    .mask (ctrl.irq_mask),
    .irq  (timer_irq)
  );

  fdc_stat_port u_stat (
    .clk      (clk),
    .ready_in (drive_ready),
    .jumpers  (jumper_open),
    .stat_q   (stat_rdata)
  );

  assign fdc_reset   = rst | ctrl.ctl_rst;
  assign dma_ack_out = dma_ack_in & ctrl.dma_en;
  assign motor_on    = ~ctrl.motor_bit;

endmodule

// File: rtl/fdc_ctl_chk.sv
module fdc_ctl_chk (
  input logic       clk,
  input logic       rst,
  input logic       host_wr,
  input logic [7:0] host_wdata,
  input logic       drive_ready,
  input logic       dma_ack_in,
  input logic [7:0] stat_rdata,
  input logic       fdc_reset,
  input logic       dma_ack_out,
  input logic       motor_on,
  input logic       timer_irq
);

  // R1
  a_r1_reset_drives_ctl: assert property (@(posedge clk) rst |-> fdc_reset);

  a_r3_gate_never_invents: assert property (@(posedge clk) disable iff (rst)
    !dma_ack_in |-> !dma_ack_out);

  a_r4_motor_inverts_write: assert property (@(posedge clk) disable iff (rst)
    host_wr |=> (motor_on == !$past(host_wdata[3])));

  a_r5_trigger_clears_irq: assert property (@(posedge clk) disable iff (rst)
    (host_wr && host_wdata[0]) |=> !timer_irq);

  a_r8_irq_sticky: assert property (@(posedge clk) disable iff (rst)
    (timer_irq && !(host_wr && host_wdata[0])) |=> timer_irq);

  a_r9_low_nibble_ones: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (stat_rdata[3:0] == 4'hF));

  a_r10_ready_inverted: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (stat_rdata[4] == !$past(drive_ready)));

  a_r11_hold_without_write: assert property (@(posedge clk) disable iff (rst)
    !host_wr |=> ($stable(motor_on) && $stable(dma_ack_out || !dma_ack_in)));

endmodule

bind fdc_ctl_top fdc_ctl_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .host_wr     (host_wr),
  .host_wdata  (host_wdata),
  .drive_ready (drive_ready),
  .dma_ack_in  (dma_ack_in),
  .stat_rdata  (stat_rdata),
  .fdc_reset   (fdc_reset),
  .dma_ack_out (dma_ack_out),
  .motor_on    (motor_on),
  .timer_irq   (timer_irq)
);

// File: tb/fdc_ctl_top_tb_top.sv
`timescale 1ns/1ps
module fdc_ctl_top_tb_top;

  localparam int P = 12;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       host_wr = 1'b0;
  logic [7:0] host_wdata = '0;
  logic       drive_ready = 1'b1;
  logic [2:0] jumper_open = '0;
  logic       dma_ack_in = 1'b0;
  logic [7:0] stat_rdata;
  logic       fdc_reset, dma_ack_out, motor_on, timer_irq;

  int n_cmp = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  fdc_ctl_top #(.PERIOD(P)) dut_i (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_wdata(host_wdata),
    .drive_ready(drive_ready), .jumper_open(jumper_open),
    .dma_ack_in(dma_ack_in), .stat_rdata(stat_rdata),
    .fdc_reset(fdc_reset), .dma_ack_out(dma_ack_out),
    .motor_on(motor_on), .timer_irq(timer_irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [7:0] v);
    host_wr = 1'b1;
    host_wdata = v;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    dma_ack_in = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 reset active", fdc_reset, 1);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset released", fdc_reset, 0);
    chk("R1 motor off", motor_on, 0);
    chk("R1 dma gate closed", dma_ack_out, 0);
    chk("R1 irq low", timer_irq, 0);

    // R2 R3 R4 R11: sweep every control byte
    for (int v = 0; v < 256; v++) begin
      logic [7:0] b;
      b = 8'(v);
      wr(b);
      chk("R2 reset bit", fdc_reset, int'(b[7]));
      chk("R4 motor", motor_on, int'(!b[3]));
      dma_ack_in = 1'b1; #0.1;
      chk("R3 gate ack high", dma_ack_out, int'(b[4]));
      dma_ack_in = 1'b0; #0.1;
      chk("R3 gate ack low", dma_ack_out, 0);
      @(negedge clk);
      chk("R11 hold motor", motor_on, int'(!b[3]));
      chk("R11 hold reset bit", fdc_reset, int'(b[7]));
    end
    wr(8'h00);
    chk("R2 cleared", fdc_reset, 0);

    // R9 R10: status sweep
    for (int v = 0; v < 16; v++) begin
      logic [3:0] s;
      s = 4'(v);
      jumper_open = s[2:0];
      drive_ready = s[3];
      @(negedge clk);
      chk("R9 status byte", int'(stat_rdata), int'({s[2:0], ~s[3], 4'hF}));
      chk("R10 ready bit", int'(stat_rdata[4]), int'(!s[3]));
    end

    // R5: basic expiry timing
    wr(8'h05);
    chk("R5 low after trigger", timer_irq, 0);
    for (int k = 1; k <= P; k++) begin
      @(negedge clk);
      chk("R5 expiry cycle", timer_irq, int'(k == P));
    end

    // R6: retrigger at every offset
    for (int j = 1; j < P; j++) begin
      wr(8'h05);
      repeat (j - 1) @(negedge clk);
      chk("R6 before retrigger", timer_irq, 0);
      wr(8'h05);
      for (int k = 1; k <= P; k++) begin
        @(negedge clk);
        chk("R6 restart period", timer_irq, int'(k == P));
      end
    end

    // R7: masked expiry
    wr(8'h01);
    for (int k = 1; k <= P + 3; k++) begin
      @(negedge clk);
      chk("R7 masked", timer_irq, 0);
    end

    // R8 R11: flag holds across non-trigger writes
    wr(8'h05);
    repeat (P) @(negedge clk);
    chk("R5 fired", timer_irq, 1);
    wr(8'h00);
    for (int k = 1; k <= P + 2; k++) begin
      @(negedge clk);
      chk("R8 holds", timer_irq, 1);
    end
    wr(8'h66);
    chk("R11 non-trigger write", timer_irq, 1);
    wr(8'h05);
    chk("R8 trigger clears", timer_irq, 0);
    repeat (P) @(negedge clk);
    chk("R5 fired again", timer_irq, 1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R8 reset clears", timer_irq, 0);
    chk("R1 motor off after reset", motor_on, 0);

    // R11: write without trigger bit starts nothing
    wr(8'h04);
    for (int k = 1; k <= P + 2; k++) begin
      @(negedge clk);
      chk("R11 no start", timer_irq, 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule